// File: doc/BRIEF.md
# Eject Event and Interrupt-Pipe Status Reporter

This block sits between a storage bridge's external pins and its USB interrupt endpoint. It watches an active-low eject button. In normal operation it reports an eject request only after the button has been held long enough to count as deliberate. While the link is suspended and the host has allowed remote wakeup, it asks for a wakeup on any movement of that pin, with no hold requirement.

The block also serves interrupt-IN polls. A rising edge on the system interrupt request pin captures a 16-bit status word from the live status inputs and marks data as pending. A poll that arrives with nothing pending is answered with NAK. A poll that arrives with data pending is answered with the captured word. The host's acknowledge clears the pending mark. Packet framing and delivery of eject events to the drive are handled elsewhere.

Top module: `eject_status_reporter`

## Requirements
- R1: Reset state: after reset, eject_pulse, wake_req, poll_nak and poll_data_vld are 0, and no status is pending.
- R2: Outside suspend, holding eject_n low for at least HOLD_CYCLES consecutive clock samples produces exactly one single-cycle eject_pulse. The pulse is visible HOLD_CYCLES+1 rising edges after eject_n first goes low, and no further pulse follows while the pin stays low.
- R3: A low hold shorter than HOLD_CYCLES samples produces no eject_pulse, and each release restarts the count.
- R4: While suspend is 1, no eject_pulse is produced, however long eject_n stays low.
- R5: While suspend and rwu_en are both 1, each level change of eject_n (falling or rising) gives a single-cycle wake_req, visible two rising edges after the change.
- R6: wake_req never rises while suspend is 0 or while rwu_en is 0.
- R7: A poll (poll_req high for one cycle) with no status pending is answered on the next cycle with poll_nak=1, poll_data_vld=0 and poll_word=0.
- R8: A rising edge on sys_irq makes status pending. Holding sys_irq high does not create a new event.
- R9: Status word layout: bit 15 disk_rdy, bit 14 hs_mode, bit 13 bus_pwr, bits 12:8 cfg_byte[7:3], bits 7:3 zero, bits 2:0 gpio[2:0]. A poll with status pending returns it with poll_data_vld=1 and poll_nak=0.
- R10: The word returned is the one captured at the event, two rising edges after sys_irq rises. Later changes to the status inputs do not alter it.
- R11: poll_ack clears pending status. A new event while status is pending replaces the captured word and keeps it pending. An event coinciding with poll_ack also keeps it pending.
- R12: poll_nak and poll_data_vld are never high together, and neither is high except on the cycle after a poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eject_n | input | 1 | Eject button, active low |
| sys_irq | input | 1 | System interrupt request; a rising edge captures status |
| disk_rdy | input | 1 | Disk-ready level |
| hs_mode | input | 1 | High-speed operation flag |
| bus_pwr | input | 1 | Bus-powered flag |
| cfg_byte | input | 8 | Configuration byte; bits 7:3 are user status bits |
| gpio | input | 3 | General-purpose pin levels |
| suspend | input | 1 | USB suspend state |
| rwu_en | input | 1 | Host has enabled remote wakeup |
| poll_req | input | 1 | Interrupt-IN poll, one cycle per poll |
| poll_ack | input | 1 | Host acknowledge of returned status |
| eject_pulse | output | 1 | Qualified eject request, one cycle |
| wake_req | output | 1 | Remote-wakeup request, one cycle |
| poll_nak | output | 1 | Poll answered with NAK |
| poll_data_vld | output | 1 | Poll answered with data |
| poll_word | output | 16 | Returned status word, zero unless poll_data_vld |

## Verification
The hardest case to reach is an interrupt event landing on the same clock edge as the host acknowledge. That edge is two cycles after the sys_irq rise, so the bench raises sys_irq and drives poll_ack exactly one cycle later. It then confirms through a poll that data is still pending and carries the new snapshot. The hold-threshold boundary is also hard to hit, so the bench sweeps hold lengths across HOLD_CYCLES-1, HOLD_CYCLES and beyond with a small HOLD_CYCLES, counting pulses per trial. The status layout is swept over all 64 combinations of the flag and GPIO inputs, each with a distinct configuration byte.

// File: rtl/esr_pkg.sv
package esr_pkg;
  localparam int STAT_W = 16;
  localparam int CFG_W  = 8;
  localparam int GPIO_W = 3;

  // Status word packing: [15] ready, [14] high speed, [13] bus powered,
  // [12:8] user bits from the config byte, [7:3] zero, [2:0] pin levels.
  function automatic logic [STAT_W-1:0] pack_status(
    input logic              rdy,
    input logic              hs,
    input logic              bp,
    input logic [CFG_W-1:0]  cfg,
    input logic [GPIO_W-1:0] pins
  );
    logic [STAT_W-1:0] w;
    w        = '0;
    w[15]    = rdy;
    w[14]    = hs;
    w[13]    = bp;
    w[12:8]  = cfg[7:3];
    w[2:0]   = pins;
    return w;
  endfunction
endpackage

// File: rtl/esr_edge_det.sv
module esr_edge_det #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic prev
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl  <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      lvl  <= d;
      prev <= lvl;
    end
  end
endmodule

// File: rtl/esr_eject_qual.sv
module esr_eject_qual #(
  parameter int HOLD_CYCLES = 300000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_lvl,
  input  logic pin_prev,
  input  logic suspend,
  input  logic rwu_en,
  output logic eject_pulse,
  output logic wake_req
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);
  localparam logic [CW-1:0] FULL = CW'(HOLD_CYCLES);

  logic [CW-1:0] hold_cnt;
  wire  pin_held   = !pin_lvl && !suspend;
  wire  pin_change = pin_lvl ^ pin_prev;
  wire  hold_done  = pin_held && (hold_cnt == LAST);
  wire  wake_fire  = suspend && rwu_en && pin_change;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_cnt    <= '0;
      eject_pulse <= 1'b0;
      wake_req    <= 1'b0;
    end else begin
      if (!pin_held)             hold_cnt <= '0;
      else if (hold_cnt != FULL) hold_cnt <= hold_cnt + 1'b1;
      eject_pulse <= hold_done;
      wake_req    <= wake_fire;
    end
  end

  AST_EJ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eject_pulse |=> !eject_pulse); // R2
  AST_EJ_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    eject_pulse |-> $past(!suspend)); // R4
  AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(suspend && rwu_en)); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cnt <= FULL); // R2
endmodule

// File: rtl/esr_status_latch.sv
module esr_status_latch
  import esr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_lvl,
  input  logic              irq_prev,
  input  logic              disk_rdy,
  input  logic              hs_mode,
  input  logic              bus_pwr,
  input  logic [CFG_W-1:0]  cfg_byte,
  input  logic [GPIO_W-1:0] gpio,
  input  logic              poll_req,
  input  logic              poll_ack,
  output logic              poll_nak,
  output logic              poll_data_vld,
  output logic [STAT_W-1:0] poll_word
);
  logic              pending;
  logic [STAT_W-1:0] snap;

  wire snap_load = irq_lvl && !irq_prev;
  wire ack_clear = poll_ack && pending && !snap_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending       <= 1'b0;
      snap          <= '0;
      poll_nak      <= 1'b0;
      poll_data_vld <= 1'b0;
      poll_word     <= '0;
    end else begin
      if (snap_load) begin
        snap    <= pack_status(disk_rdy, hs_mode, bus_pwr, cfg_byte, gpio);
        pending <= 1'b1;
      end else if (ack_clear) begin
        pending <= 1'b0;
      end
      poll_nak      <= poll_req && !pending;
      poll_data_vld <= poll_req && pending;
      poll_word     <= (poll_req && pending) ? snap : '0;
    end
  end

  AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(poll_nak && poll_data_vld)); // R12
  AST_RESP_AFTER_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_nak || poll_data_vld) |-> $past(poll_req)); // R12
  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !poll_ack) |=> pending); // R11
  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    snap_load |=> pending); // R8
  AST_WORD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_data_vld |-> (poll_word == '0)); // R7
endmodule

// File: rtl/eject_status_reporter.sv
module eject_status_reporter #(
  parameter int HOLD_CYCLES = 300000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        eject_n,
  input  logic        sys_irq,
  input  logic        disk_rdy,
  input  logic        hs_mode,
  input  logic        bus_pwr,
  input  logic [7:0]  cfg_byte,
  input  logic [2:0]  gpio,
  input  logic        suspend,
  input  logic        rwu_en,
  input  logic        poll_req,
  input  logic        poll_ack,
  output logic        eject_pulse,
  output logic        wake_req,
  output logic        poll_nak,
  output logic        poll_data_vld,
  output logic [15:0] poll_word
);
  logic ej_lvl, ej_prev, irq_lvl, irq_prev;

  esr_edge_det #(.RST_VAL(1'b1)) u_ej_edge (
    .clk(clk), .rst_n(rst_n), .d(eject_n), .lvl(ej_lvl), .prev(ej_prev));

  esr_edge_det #(.RST_VAL(1'b0)) u_irq_edge (
    .clk(clk), .rst_n(rst_n), .d(sys_irq), .lvl(irq_lvl), .prev(irq_prev));

  esr_eject_qual #(.HOLD_CYCLES(HOLD_CYCLES)) u_qual (
    .clk(clk), .rst_n(rst_n), .pin_lvl(ej_lvl), .pin_prev(ej_prev),
    .suspend(suspend), .rwu_en(rwu_en),
    .eject_pulse(eject_pulse), .wake_req(wake_req));

  esr_status_latch u_stat (
    .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .irq_prev(irq_prev),
    .disk_rdy(disk_rdy), .hs_mode(hs_mode), .bus_pwr(bus_pwr),
    .cfg_byte(cfg_byte), .gpio(gpio),
    .poll_req(poll_req), .poll_ack(poll_ack),
    .poll_nak(poll_nak), .poll_data_vld(poll_data_vld), .poll_word(poll_word));
endmodule

// File: tb/eject_status_reporter_bench.sv
`timescale 1ns/1ps
module eject_status_reporter_bench;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eject_n = 1'b1, sys_irq = 1'b0, disk_rdy = 1'b0, hs_mode = 1'b0, bus_pwr = 1'b0;
  logic [7:0] cfg_byte = 8'h00;
  logic [2:0] gpio = 3'b000;
  logic suspend = 1'b0, rwu_en = 1'b0, poll_req = 1'b0, poll_ack = 1'b0;
  logic eject_pulse, wake_req, poll_nak, poll_data_vld;
  logic [15:0] poll_word;

  int total = 0, bad = 0;
  int ej_seen = 0, wk_seen = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  eject_status_reporter #(.HOLD_CYCLES(H)) u_eject_status_reporter (
    .clk(clk), .rst_n(rst_n), .eject_n(eject_n), .sys_irq(sys_irq),
    .disk_rdy(disk_rdy), .hs_mode(hs_mode), .bus_pwr(bus_pwr),
    .cfg_byte(cfg_byte), .gpio(gpio), .suspend(suspend), .rwu_en(rwu_en),
    .poll_req(poll_req), .poll_ack(poll_ack),
    .eject_pulse(eject_pulse), .wake_req(wake_req), .poll_nak(poll_nak),
    .poll_data_vld(poll_data_vld), .poll_word(poll_word));

  always @(negedge clk) begin
    if (eject_pulse) ej_seen++;
    if (wake_req)    wk_seen++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_word(input logic r, input logic h,
      input logic b, input logic [7:0] c, input logic [2:0] g);
    return {r, h, b, c[7:3], 5'd0, g};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // poll and return {nak, vld, word}
  task automatic do_poll(output logic n, output logic v, output logic [15:0] w);
    poll_req = 1'b1; step(1); poll_req = 1'b0;
    n = poll_nak; v = poll_data_vld; w = poll_word;
  endtask

  task automatic do_ack();
    poll_ack = 1'b1; step(1); poll_ack = 1'b0;
  endtask

  task automatic raise_irq();
    sys_irq = 1'b1; step(3); sys_irq = 1'b0; step(1);
  endtask

  task automatic hold_low(input int len);
    eject_n = 1'b0; step(len); eject_n = 1'b1; step(4);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic n, v;
    logic [15:0] w, exp_w;
    step(3);
    // R1 reset state
    chk("R1 outputs", {eject_pulse, wake_req, poll_nak, poll_data_vld}, 0);
    rst_n = 1'b1; step(2);
    do_poll(n, v, w);
    chk("R1 no pending nak", n, 1); chk("R1 no pending vld", v, 0);
    step(1);
    // R7 nak response details
    do_poll(n, v, w);
    chk("R7 nak", n, 1); chk("R7 vld", v, 0); chk("R7 word", w, 0);
    step(1);
    chk("R12 quiet after poll", {poll_nak, poll_data_vld}, 0);

    // R2 exact timing
    ej_seen = 0;
    eject_n = 1'b0;
    step(H); chk("R2 before edge", eject_pulse, 0);
    step(1); chk("R2 pulse edge", eject_pulse, 1);
    step(1); chk("R2 single cycle", eject_pulse, 0);
    step(3 * H); chk("R2 one pulse while held", ej_seen, 1);
    eject_n = 1'b1; step(4);

    // R2/R3 hold length sweep
    for (int len = 1; len <= H + 3; len++) begin
      ej_seen = 0;
      hold_low(len);
      chk(len >= H ? "R2 hold sweep" : "R3 short hold", ej_seen, (len >= H) ? 1 : 0);
    end
    // R3 restart: two short holds with a brief release
    ej_seen = 0;
    eject_n = 1'b0; step(H - 2); eject_n = 1'b1; step(1);
    eject_n = 1'b0; step(H - 2); eject_n = 1'b1; step(4);
    chk("R3 count restarts", ej_seen, 0);

    // R4 suspended long hold, remote wakeup off
    suspend = 1'b1; rwu_en = 1'b0; step(2);
    ej_seen = 0; wk_seen = 0;
    hold_low(4 * H);
    chk("R4 no eject in suspend", ej_seen, 0);
    chk("R6 no wake rwu off", wk_seen, 0);

    // R5 wake on both edges
    rwu_en = 1'b1; step(2);
    eject_n = 1'b0;
    step(1); chk("R5 fall early", wake_req, 0);
    step(1); chk("R5 fall wake", wake_req, 1);
    step(1); chk("R5 fall single", wake_req, 0);
    step(3);
    eject_n = 1'b1;
    step(1); chk("R5 rise early", wake_req, 0);
    step(1); chk("R5 rise wake", wake_req, 1);
    step(1); chk("R5 rise single", wake_req, 0);
    // R6 awake with rwu set
    suspend = 1'b0; step(2);
    wk_seen = 0;
    hold_low(2);
    chk("R6 no wake awake", wk_seen, 0);
    rwu_en = 1'b0;

    // R9 layout sweep
    for (int i = 0; i < 64; i++) begin
      disk_rdy = i[5]; hs_mode = i[4]; bus_pwr = i[3]; gpio = i[2:0];
      cfg_byte = 8'((i * 37) ^ 8'h5A);
      exp_w = expect_word(i[5], i[4], i[3], 8'((i * 37) ^ 8'h5A), i[2:0]);
      raise_irq();
      do_poll(n, v, w);
      chk("R9 vld", {n, v}, 2'b01);
      chk("R9 word", w, exp_w);
      do_ack(); step(1);
    end

    // R10 snapshot at event
    disk_rdy = 1; hs_mode = 0; bus_pwr = 1; cfg_byte = 8'hA8; gpio = 3'b101;
    exp_w = expect_word(1, 0, 1, 8'hA8, 3'b101);
    sys_irq = 1'b1; step(2);
    disk_rdy = 0; hs_mode = 1; bus_pwr = 0; cfg_byte = 8'h17; gpio = 3'b010;
    step(2);
    do_poll(n, v, w);
    chk("R10 snapshot kept", w, exp_w);
    // R8 held irq no retrigger
    do_ack(); step(2);
    do_poll(n, v, w);
    chk("R8 held irq no event", {n, v}, 2'b10);
    sys_irq = 1'b0; step(2);

    // R11 update while pending
    disk_rdy = 0; hs_mode = 0; bus_pwr = 0; cfg_byte = 8'hF8; gpio = 3'b001;
    raise_irq();
    disk_rdy = 1; hs_mode = 1; bus_pwr = 1; cfg_byte = 8'h08; gpio = 3'b110;
    raise_irq();
    do_poll(n, v, w);
    chk("R11 replaced word", w, expect_word(1, 1, 1, 8'h08, 3'b110));
    do_poll(n, v, w);
    chk("R11 still pending", v, 1);
    do_ack(); step(1);
    do_poll(n, v, w);
    chk("R11 ack clears", {n, v}, 2'b10);
    // R11 event coinciding with ack
    raise_irq();
    cfg_byte = 8'h50; gpio = 3'b011;
    sys_irq = 1'b1; step(1);
    poll_ack = 1'b1; step(1); poll_ack = 1'b0;
    step(2); sys_irq = 1'b0;
    do_poll(n, v, w);
    chk("R11 event beats ack", v, 1);
    chk("R11 event beats ack word", w, expect_word(1, 1, 1, 8'h50, 3'b011));
    do_ack(); step(2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule